// File: doc/BRIEF.md
# Edge-Captured Storage Stage with Completion Detection

This block is a cycle-level model of a normally closed storage unit for a handshaking pipeline stage. The data output never follows the data input while the stage is idle; a value moves from `din` to `dout` only when a rising edge on `trig` is seen. Activity on `din` at any other time, short pulses included, cannot reach the output.

Completion is not taken from a fixed delay alone. A comparator checks, bit by bit, that the value sitting at the storage input matches the value the storage now holds. `done` rises only when that match holds and a copy of `trig` delayed by `TRIG_DELAY` cycles is high. `done` falls after `trig` falls, following the return-to-zero order of a four-phase handshake. A producer raises `trig`, waits for `done`, lowers `trig` and waits for `done` to fall before the next transfer.

Top module: `ets_top`

## Requirements
- R1: The clock edge that first samples `trig` high after it was sampled low (or after reset) is the capture edge. It loads `din` into the storage input stage. `dout` shows that value from the next clock edge on.
- R2: Between capture edges `dout` holds its value, whatever `din` does.
- R3: While `done` is high, `dout` equals the value loaded at the storage input.
- R4: `done` rises only in a cycle after the delayed trigger (`trig` delayed by `TRIG_DELAY` cycles) was high and the storage input and output were equal.
- R5: Count the capture edge as edge 0. `done` rises at edge max(`TRIG_DELAY`,2) for a value that differs from the one held before. It rises at edge max(`TRIG_DELAY`,1) for a value equal to it, because the comparison already holds.
- R6: Count the edge that first samples `trig` low as edge 0. `done` falls at edge `TRIG_DELAY`.
- R7: While `rst_n` is low, `dout` is all zeros and `done` is 0. This holds when reset is applied in the middle of operation too.
- R8: Holding `trig` high captures only once. Changes on `din` during that time reach neither `dout` nor `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the user |
| din | input | W | Data presented to the storage unit |
| trig | input | 1 | Capture request; its rising edge loads `din` |
| dout | output | W | Stored data |
| done | output | 1 | Completion: stored data is valid and the delayed trigger is high |

## Verification
The bench builds the block with `W` = 8 and `TRIG_DELAY` = 1. With a one-cycle delay the comparator, not the delay line, decides when `done` rises. A repeated value therefore completes one cycle sooner than a new value, and R5 becomes observable in both of its forms. Transfers run with `din` toggling before, during and after each capture. Reset is also applied in mid-transfer to exercise R7.

// File: rtl/ets_pkg.sv
package ets_pkg;

  typedef enum logic [1:0] {
    CMP_IDLE  = 2'd0,
    CMP_ARMED = 2'd1,
    CMP_DONE  = 2'd2
  } cmp_state_t;

endpackage

// File: rtl/ets_edge.sv
// Rising-edge detector on the capture request.
module ets_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic fire
);
  logic trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig;
  end

  assign fire = trig & ~trig_q;
endmodule

// File: rtl/ets_delay.sv
// Delay line for the trigger, TRIG_DELAY stages.
module ets_delay #(
  parameter int TRIG_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic trig_dly
);
  logic [TRIG_DELAY-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < TRIG_DELAY; g++) begin : g_stage
      logic stage_d;
      if (g == 0) begin : g_first
        assign stage_d = trig;
      end else begin : g_rest
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign trig_dly = stage_q[TRIG_DELAY-1];
endmodule

// File: rtl/ets_store.sv
// Closed storage: input stage loads on capture, output follows one cycle later.
module ets_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [W-1:0] din,
  output logic [W-1:0] cap_in,
  output logic         pend,
  output logic [W-1:0] dout
);
  logic [W-1:0] cap_in_d, dout_d;
  logic         pend_d;

  always_comb begin
    cap_in_d = cap_in;
    if (fire) cap_in_d = din;
    pend_d = fire;
    dout_d = dout;
    if (pend) dout_d = cap_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_in <= '0;
      pend   <= 1'b0;
      dout   <= '0;
    end else begin
      cap_in <= cap_in_d;
      pend   <= pend_d;
      dout   <= dout_d;
    end
  end
endmodule

// File: rtl/ets_complete.sv
// Completion detection: equality of storage input and output, gated by delayed trigger.
module ets_complete #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic         trig_dly,
  input  logic [W-1:0] cap_in,
  input  logic [W-1:0] dout,
  output logic         done
);
  import ets_pkg::*;

  cmp_state_t state_q, state_d;
  logic       match;

  assign match = &(~(cap_in ^ dout));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CMP_IDLE:  if (fire) state_d = CMP_ARMED;
      CMP_ARMED: if (trig_dly && match) state_d = CMP_DONE;
      CMP_DONE:  begin
        if (fire)           state_d = CMP_ARMED;
        else if (!trig_dly) state_d = CMP_IDLE;
      end
      default:   state_d = CMP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CMP_IDLE;
    else        state_q <= state_d;
  end

  assign done = (state_q == CMP_DONE);
endmodule

// File: rtl/ets_top.sv
module ets_top #(
  parameter int W          = 8,
  parameter int TRIG_DELAY = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         trig,
  output logic [W-1:0] dout,
  output logic         done
);
  logic         fire, trig_dly, pend;
  logic [W-1:0] cap_in;

  ets_edge u_edge (
    .clk(clk), .rst_n(rst_n), .trig(trig), .fire(fire)
  );

  ets_delay #(.TRIG_DELAY(TRIG_DELAY)) u_delay (
    .clk(clk), .rst_n(rst_n), .trig(trig), .trig_dly(trig_dly)
  );

  ets_store #(.W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .fire(fire), .din(din),
    .cap_in(cap_in), .pend(pend), .dout(dout)
  );

  ets_complete #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .fire(fire), .trig_dly(trig_dly),
    .cap_in(cap_in), .dout(dout), .done(done)
  );
endmodule

// File: rtl/ets_top_chk.sv
module ets_top_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         trig,
  input logic [W-1:0] din,
  input logic [W-1:0] dout,
  input logic         done,
  input logic [W-1:0] cap_in,
  input logic         pend,
  input logic         trig_dly
);
  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !$past(trig)) |=> (cap_in == $past(din)));

  assert_dout_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pend) |-> (dout == $past(dout)));

  assert_done_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dout == cap_in));

  assert_done_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(trig_dly) && ($past(cap_in) == $past(dout))));

  assert_done_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> !$past(trig_dly));
endmodule

bind ets_top ets_top_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .din(din), .dout(dout),
  .done(done), .cap_in(cap_in), .pend(pend), .trig_dly(trig_dly)
);

// File: tb/test_ets_top.sv
module test_ets_top;
  localparam int W  = 8;
  localparam int DL = 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] din = '0;
  logic         trig = 1'b0;
  logic [W-1:0] dout;
  logic         done;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] expq[$];
  logic [W-1:0] held = '0;

  always #2 clk = ~clk;

  ets_top #(.W(W), .TRIG_DELAY(DL)) i_ets_top (
    .clk(clk), .rst_n(rst_n), .din(din), .trig(trig), .dout(dout), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: on every rising done, pop expected value and compare (R1, R3).
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (done && !done_prev) begin
      if (expq.size() == 0) check("R4 done without capture", 1, 0);
      else check("R1/R3 dout at done", dout, expq.pop_front());
    end
    done_prev <= done;
  end

  // Driver: one four-phase transfer with din glitching throughout.
  task automatic xfer(input logic [W-1:0] v, input int hold_extra);
    int n, lat_exp;
    lat_exp = (v == held) ? ((DL > 1 ? DL : 1) + 1) : ((DL > 2 ? DL : 2) + 1);
    @(negedge clk);
    din = v; trig = 1'b1;
    expq.push_back(v);
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk); n++;
      din = ~din ^ W'(n);
      if (n == 1) check("R2 dout before update", dout, held);
    end
    check("R5 rise latency", n, lat_exp);
    held = v;
    for (int k = 0; k < hold_extra; k++) begin
      @(negedge clk);
      din = din + 8'h35;
      check("R8 dout while trig held", dout, v);
      check("R8 done while trig held", done, 1);
    end
    trig = 1'b0;
    n = 0;
    while (done && n < 40) begin
      @(negedge clk); n++;
      din = din ^ 8'h5A;
    end
    check("R6 fall latency", n, DL + 1);
    check("R2 dout after return", dout, v);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #40000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 dout in reset", dout, 0);
    check("R7 done in reset", done, 0);
    rst_n = 1'b1;
    // Idle glitches with trig low (R2).
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); din = 8'h11 * i[7:0];
      check("R2 idle dout", dout, 0);
    end
    xfer(8'hA5, 0);
    xfer(8'hA5, 2);   // repeated value: shorter wait (R5)
    xfer(8'h3C, 3);
    xfer(8'h00, 0);
    xfer(8'hFF, 1);
    xfer(8'hFF, 0);
    // Mid-transfer reset (R7).
    @(negedge clk); din = 8'h77; trig = 1'b1;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7 dout after mid reset", dout, 0);
    check("R7 done after mid reset", done, 0);
    expq.delete();
    trig = 1'b0;
    held = '0;
    @(negedge clk); rst_n = 1'b1;
    xfer(8'h42, 1);
    repeat (3) @(negedge clk);
    check("R1 queue drained", expq.size(), 0);
    summary();
  end
endmodule